// File: doc/BRIEF.md
# Bit-Serial Binary Adder

This block adds two unsigned binary numbers that arrive one bit per clock, least-significant bit first. On every cycle marked by the bit-valid strobe it combines the current bit of each operand with a stored carry and produces one bit of the sum. The only state is that carry, held in a single flip-flop. After each valid bit it is loaded with the carry that the full adder generates. The block is therefore a two-state Mealy machine and not a parallel adder.

Software or a neighbouring block starts a new addition by pulsing the synchronous clear, which empties the carry. It then streams the operand bits in on cycles where the valid strobe is high. The sum bit depends combinationally on the present operand bits and the stored carry, so the consumer captures it in the same cycle it presents the operands. After the last bit, the carry flag shows the carry out of the most significant position, which is the overflow of the fixed-width addition. The operand slice width is a parameter with a default of one bit per cycle. Wider slices ripple through a short chain of adder cells.

Top module: `bit_serial_adder`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the carry flag is 0 after that edge.
- R2: The sum output equals operand bit A XOR operand bit B XOR the stored carry, whether or not the valid strobe is high.
- R3: On a clock edge with valid high and clear low, the stored carry becomes the majority of A, B and the old carry. From carry 0, inputs AB = 00, 01, 10 and 11 give carry 0, 0, 0 and 1. From carry 1 they give 0, 1, 1 and 1.
- R4: On a clock edge with valid low and clear low, the stored carry keeps its value, whatever the operand bits are.
- R5: On a clock edge with clear high, the stored carry becomes 0. Clear takes priority over valid.
- R6: The carry flag output always shows the stored carry. After the last bit of an N-bit addition it equals bit N of A+B.
- R7: Operands fed LSB first after a clear produce, in order, the N low bits of A+B on the sum output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the carry that starts a new addition |
| bit_vld | input | 1 | High on cycles that carry an operand bit |
| a_bit | input | SLICE_W | Operand A bit(s) for this cycle |
| b_bit | input | SLICE_W | Operand B bit(s) for this cycle |
| sum_bit | output | SLICE_W | Sum bit(s) for this cycle, combinational |
| carry_out | output | 1 | Stored carry; overflow flag after the last bit |

## Verification
On every cycle, the assertions check the carry flop's next-state rules: a carry that generate forces to 1, a carry that kill forces to 0, holding while the strobe is low, and clear winning over valid. The bench's scenarios are the only place that shows complete additions. In those, the collected sum and the final carry are compared with an ordinary integer sum. This covers carry chains that propagate across many bit positions, such as all-ones plus one. The bench also walks the full two-state table and checks the carry after reset.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_res_t;

  function automatic fa_res_t fa_eval(input logic x, input logic y, input logic cin);
    fa_res_t r;
    r.sum  = x ^ y ^ cin;
    r.cout = (x & y) | (x & cin) | (y & cin);
    return r;
  endfunction

endpackage

// File: rtl/sa_full_adder_cell.sv
module sa_full_adder_cell
  import serial_add_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  fa_res_t res;

  always_comb begin
    res    = fa_eval(x_i, y_i, cin_i);
    sum_o  = res.sum;
    cout_o = res.cout;
  end
endmodule

// File: rtl/sa_slice_chain.sv
module sa_slice_chain #(
  parameter int SLICE_W = 1
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);
  localparam int NODES = SLICE_W + 1;

  logic [NODES-1:0] rip;

  assign rip[0] = cin_i;

  for (genvar k = 0; k < SLICE_W; k++) begin : g_cell
    sa_full_adder_cell u_cell (
      .x_i   (a_i[k]),
      .y_i   (b_i[k]),
      .cin_i (rip[k]),
      .sum_o (sum_o[k]),
      .cout_o(rip[k+1])
    );
  end

  assign cout_o = rip[NODES-1];
endmodule

// File: rtl/sa_carry_reg.sv
module sa_carry_reg #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  input  logic carry_d,
  output logic carry_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      carry_q <= INIT_VAL;
    end else if (load) begin
      carry_q <= carry_d;
    end
  end

  // R4: with neither clear nor load the flop keeps its value
  assert_carry_hold_R4 : assert property (@(posedge clk) disable iff (rst)
    (!clear && !load) |=> $stable(carry_q));

  // R5: clear empties the carry even when a load is requested
  assert_clear_wins_R5 : assert property (@(posedge clk) disable iff (rst)
    clear |=> (carry_q == INIT_VAL));
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int SLICE_W = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               bit_vld,
  input  logic [SLICE_W-1:0] a_bit,
  input  logic [SLICE_W-1:0] b_bit,
  output logic [SLICE_W-1:0] sum_bit,
  output logic               carry_out
);
  localparam int TOP = SLICE_W - 1;

  logic carry_q;
  logic carry_nxt;

  sa_slice_chain #(.SLICE_W(SLICE_W)) u_chain (
    .a_i   (a_bit),
    .b_i   (b_bit),
    .cin_i (carry_q),
    .sum_o (sum_bit),
    .cout_o(carry_nxt)
  );

  sa_carry_reg #(.INIT_VAL(1'b0)) u_carry (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .load   (bit_vld),
    .carry_d(carry_nxt),
    .carry_q(carry_q)
  );

  assign carry_out = carry_q;

  // R3: both top operand bits set generate a carry irrespective of the old one
  assert_carry_generate_R3 : assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !clear && a_bit[TOP] && b_bit[TOP]) |=> carry_out);

  // R3: both top operand bits clear kill the carry
  assert_carry_kill_R3 : assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !clear && !a_bit[TOP] && !b_bit[TOP]) |=> !carry_out);
endmodule

// File: tb/test_bit_serial_adder.sv
`timescale 1ns/1ps
module test_bit_serial_adder;
  localparam real HALF = 2.5;
  localparam int  NBITS = 16;

  logic clk = 1'b0;
  logic rst, clear, bit_vld;
  logic [0:0] a_bit, b_bit, sum_bit;
  logic carry_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  bit_serial_adder #(.SLICE_W(1)) i_bit_serial_adder (
    .clk(clk), .rst(rst), .clear(clear), .bit_vld(bit_vld),
    .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_bit), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle; sum sampled mid-cycle, carry sampled after the edge
  task automatic step(input logic a, input logic b, input logic v, input logic c,
                      output logic s);
    @(negedge clk);
    a_bit = a; b_bit = b; bit_vld = v; clear = c;
    #1 s = sum_bit[0];
    @(posedge clk);
    #1;
  endtask

  task automatic set_carry(input logic val);
    logic s;
    step(1'b0, 1'b0, 1'b0, 1'b1, s);
    if (val) step(1'b1, 1'b1, 1'b1, 1'b0, s);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; clear = 1'b0; bit_vld = 1'b1; a_bit = 1'b1; b_bit = 1'b1;
    @(posedge clk); #1;
    check("R1 carry after reset", carry_out, 1'b0);
    @(negedge clk);
    rst = 1'b0; bit_vld = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
  endtask

  task automatic t_state_table;
    logic s;
    for (int q = 0; q < 2; q++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic a, b, exp_s, exp_c;
        a = ab[1]; b = ab[0];
        exp_s = a ^ b ^ q[0];
        exp_c = (a & b) | (a & q[0]) | (b & q[0]);
        set_carry(q[0]);
        check("R6 carry flag shows stored carry", carry_out, q[0]);
        step(a, b, 1'b1, 1'b0, s);
        check("R2 sum bit", s, exp_s);
        check("R3 next carry", carry_out, exp_c);
      end
    end
  endtask

  task automatic t_hold;
    logic s;
    set_carry(1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, s);
    check("R2 sum with valid low", s, 1'b1);
    check("R4 carry held on 00", carry_out, 1'b1);
    set_carry(1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, s);
    check("R2 sum with valid low", s, 1'b0);
    check("R4 carry held on 11", carry_out, 1'b0);
  endtask

  task automatic t_clear_priority;
    logic s;
    set_carry(1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, s);
    check("R5 clear beats valid", carry_out, 1'b0);
  endtask

  task automatic t_add(input logic [NBITS-1:0] a, input logic [NBITS-1:0] b);
    logic [NBITS:0] exp_sum;
    logic [NBITS-1:0] got;
    logic s;
    exp_sum = {1'b0, a} + {1'b0, b};
    set_carry(1'b0);
    for (int i = 0; i < NBITS; i++) begin
      step(a[i], b[i], 1'b1, 1'b0, s);
      got[i] = s;
      // idle gap between some bits must not disturb the result (R4)
      if (i % 5 == 2) step(~a[i], ~b[i], 1'b0, 1'b0, s);
    end
    vectors++;
    if (got !== exp_sum[NBITS-1:0]) begin
      miscompares++;
      $display("FAIL R7 serial sum: actual %h expected %h", got, exp_sum[NBITS-1:0]);
    end
    check("R6 final carry", carry_out, exp_sum[NBITS]);
  endtask

  initial begin
    rst = 1'b1; clear = 1'b0; bit_vld = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
    t_reset();
    t_state_table();
    t_hold();
    t_clear_priority();
    t_add(16'hFFFF, 16'h0001);
    t_add(16'h0000, 16'h0000);
    t_add(16'hFFFF, 16'hFFFF);
    t_add(16'h8000, 16'h8000);
    t_add(16'h5555, 16'hAAAA);
    for (int n = 0; n < 20; n++) begin
      logic [NBITS-1:0] ra, rb;
      ra = NBITS'($urandom);
      rb = NBITS'($urandom);
      t_add(ra, rb);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule